// File: doc/BRIEF.md
# UART Transceiver with Expansion-Bit Station Addressing

This block is a full-duplex serial transceiver for multidrop links. Each character is sent as a start bit, eight data bits least significant first, an optional ninth "expansion" bit and a stop bit. A sender uses the expansion bit to mark station-address characters. A receiver uses it to decide which characters belong to this station. A five-field option register sets the behaviour. It can only be rewritten while the block is held idle with `run` low.

The receiver sorts each good frame as an address frame or a plain frame. An address frame is one whose expansion bit equals the programmed detection level. When station filtering is on, an address frame carrying `station_id` opens the station and is delivered. An address frame carrying any other value closes the station and is dropped. Plain frames are delivered only while the station is open. The transmitter takes the expansion bit from its own input, latched with the byte. It raises its interrupt either when a frame starts or when it ends.

Both directions share one oversampling tick that runs at 16 times the bit rate. A bit lasts 16 × `CLK_DIV` clock cycles.

Top module: `uart_xbit_transceiver`

## Requirements
- R1: The option register reads back as 8 bits. Bit 0 enables the expansion bit, bit 1 is the detection level, bit 2 enables station filtering, bit 3 selects the transmit interrupt at completion (1) or at start (0), and bit 4 disables the expansion-bit comparison. Bits 7..5 always read 0, and all fields reset to 0.
- R2: A write to the option register takes effect only while `run` is low. A write while `run` is high leaves the register unchanged.
- R3: `txd` idles high. A frame is start (0), 8 data bits LSB first, the expansion bit only when bit 0 is set, then stop (1). Each bit lasts 16 × `CLK_DIV` cycles, so a frame keeps `tx_busy` high for 10 or 11 bit times, less at most one tick period.
- R4: `tx_irq` is a one-cycle pulse, exactly one per frame. It rises in the cycle after a start is accepted when bit 3 is 0, and in the cycle `tx_busy` falls when bit 3 is 1.
- R5: `tx_start` is ignored while `tx_busy` is high or while `run` is low. The data and expansion bit are latched when the start is accepted.
- R6: Each good frame that is accepted gives a one-cycle `rx_irq` pulse, with `rx_data` holding the received byte and `rx_xbit` the received expansion bit (0 when the expansion bit is disabled).
- R7: `rx_addr` is 1 for an accepted frame only when the expansion bit is enabled, the comparison is not disabled, and the received expansion bit equals bit 1. Otherwise it is 0.
- R8: Filtering is active when bits 0 and 2 are set and bit 4 is clear. While it is active: an address frame whose data equals `station_id` sets `match_flag` and is accepted; an address frame with any other data clears `match_flag` and is dropped; a plain frame is accepted only while `match_flag` is set. While filtering is inactive, every good frame is accepted. `match_flag` is cleared while `run` is low.
- R9: A frame whose stop bit samples low gives a one-cycle `rx_ferr` pulse, no `rx_irq`, and leaves `match_flag` unchanged.
- R10: After reset: `txd` = 1, `tx_busy` = 0, `tx_irq` = `rx_irq` = `rx_ferr` = 0, `match_flag` = 0, and the option register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | 1 = operating, 0 = idle (configuration allowed) |
| cfg_we | input | 1 | Option register write strobe |
| cfg_wdata | input | 8 | Option register write value |
| cfg_rdata | output | 8 | Option register contents |
| station_id | input | 8 | Station address compared when filtering |
| tx_start | input | 1 | Request to send one frame |
| tx_data | input | 8 | Byte to send |
| tx_xbit | input | 1 | Expansion bit to send |
| tx_busy | output | 1 | Frame in progress |
| tx_irq | output | 1 | Transmit interrupt pulse |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_irq | output | 1 | Receive interrupt pulse |
| rx_ferr | output | 1 | Framing-error pulse |
| rx_data | output | 8 | Last accepted byte |
| rx_xbit | output | 1 | Expansion bit of the last accepted frame |
| rx_addr | output | 1 | Last accepted frame was an address frame |
| match_flag | output | 1 | Station currently selected |

## Verification
The assertions check on every cycle the properties that hold at any moment:
- the reserved bits of the option register read 0, and the register cannot change while operating;
- the interrupt and error pulses last one cycle and never coincide;
- the line is high whenever no frame is in progress;
- `run` low clears the transmitter;
- an accepted frame never reports an address while the comparison is off;
- under filtering, an accepted frame always has `match_flag` set.

Only the bench's scenarios can show the rest: that a byte sent through the loopback comes back with the right data and expansion bit, that the frame length follows the expansion setting, and when the transmit interrupt fires. They also cover how the station filter opens and closes across a sequence of address and plain frames, and that a framing error leaves that state alone.

// File: rtl/uxb_pkg.sv
// Shared types and constants for the expansion-bit UART.
// Assumes a fixed 16x oversampling ratio with mid-bit sampling.
package uxb_pkg;
    localparam int OVS = 16;
    localparam int MID = OVS / 2;

    // Option fields; the packed order places xen at bit 0 of the register
    typedef struct packed {
        logic cmp_dis;     // bit 4
        logic tx_irq_end;  // bit 3
        logic filt_en;     // bit 2
        logic lvl;         // bit 1
        logic xen;         // bit 0
    } uxb_cfg_t;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2,
        RX_WAITH = 2'd3
    } uxb_rx_state_t;
endpackage

// File: rtl/uxb_baud.sv
// Oversampling tick generator: one-cycle tick every CLK_DIV clocks.
// Assumes CLK_DIV >= 1; the counter rests at zero while run is low.
module uxb_baud #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic [CW-1:0] cnt;

    // Divide the clock down to the oversampling rate
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(CLK_DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uxb_tx.sv
// Transmitter: serialises start, data LSB first, optional expansion bit, stop.
// Assumes the configuration is stable while run is high.
module uxb_tx
    import uxb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  uxb_cfg_t          cfg,
    input  logic              tx_start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_xbit,
    output logic              txd,
    output logic              tx_busy,
    output logic              tx_irq
);
    localparam int FW = DATA_W + 3;
    localparam int IW = $clog2(FW + 1);
    localparam int OW = $clog2(OVS);

    logic [FW-1:0] sh;
    logic [IW-1:0] left;
    logic [OW-1:0] tcnt;
    logic          accept;

    assign accept = run && tx_start && !tx_busy;

    // Frame sequencing, shifting and interrupt generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_busy <= 1'b0;
            txd     <= 1'b1;
            tx_irq  <= 1'b0;
            sh      <= '1;
            left    <= '0;
            tcnt    <= '0;
        end else begin
            tx_irq <= 1'b0;
            if (!run) begin
                tx_busy <= 1'b0;
                txd     <= 1'b1;
            end else if (accept) begin
                tx_busy <= 1'b1;
                txd     <= 1'b0;
                tcnt    <= '0;
                tx_irq  <= !cfg.tx_irq_end;
                if (cfg.xen) begin
                    sh   <= {1'b1, tx_xbit, tx_data, 1'b0};
                    left <= IW'(FW - 1);
                end else begin
                    sh   <= {1'b1, 1'b1, tx_data, 1'b0};
                    left <= IW'(FW - 2);
                end
            end else if (tx_busy && tick) begin
                if (tcnt == OW'(OVS - 1)) begin
                    tcnt <= '0;
                    if (left == '0) begin
                        tx_busy <= 1'b0;
                        txd     <= 1'b1;
                        tx_irq  <= cfg.tx_irq_end;
                    end else begin
                        sh   <= {1'b1, sh[FW-1:1]};
                        txd  <= sh[1];
                        left <= left - 1'b1;
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uxb_rx.sv
// Receiver framer: finds the start edge, samples each bit at mid-point and
// hands a completed frame (data, expansion bit, stop level) on as a pulse.
// Assumes the configuration is stable while run is high.
module uxb_rx
    import uxb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              xen,
    input  logic              rxd,
    output logic              fr_valid,
    output logic [DATA_W-1:0] fr_data,
    output logic              fr_xbit,
    output logic              fr_stop
);
    localparam int BW = $clog2(DATA_W + 2);
    localparam int OW = $clog2(OVS);

    uxb_rx_state_t   st;
    logic [1:0]      sync;
    logic            line;
    logic [DATA_W+1:0] bits;
    logic [BW-1:0]   bidx;
    logic [BW-1:0]   last;
    logic [OW-1:0]   tcnt;

    assign line = sync[1];
    assign last = xen ? BW'(DATA_W + 1) : BW'(DATA_W);

    // Two-stage synchroniser on the serial input
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    // Start detection, mid-bit sampling and frame hand-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= RX_IDLE;
            bits     <= '0;
            bidx     <= '0;
            tcnt     <= '0;
            fr_valid <= 1'b0;
            fr_data  <= '0;
            fr_xbit  <= 1'b0;
            fr_stop  <= 1'b1;
        end else begin
            fr_valid <= 1'b0;
            if (!run) begin
                st <= RX_IDLE;
            end else begin
                case (st)
                    RX_IDLE: begin
                        if (!line) begin
                            st   <= RX_START;
                            tcnt <= '0;
                        end
                    end
                    RX_START: begin
                        if (tick) begin
                            if (tcnt == OW'(MID - 1)) begin
                                tcnt <= '0;
                                bidx <= '0;
                                st   <= line ? RX_IDLE : RX_BITS;
                            end else begin
                                tcnt <= tcnt + 1'b1;
                            end
                        end
                    end
                    RX_BITS: begin
                        if (tick) begin
                            if (tcnt == OW'(OVS - 1)) begin
                                tcnt       <= '0;
                                bits[bidx] <= line;
                                bidx       <= bidx + 1'b1;
                                if (bidx == last) begin
                                    fr_valid <= 1'b1;
                                    fr_stop  <= line;
                                    fr_data  <= bits[DATA_W-1:0];
                                    fr_xbit  <= xen & bits[DATA_W];
                                    st       <= line ? RX_IDLE : RX_WAITH;
                                end
                            end else begin
                                tcnt <= tcnt + 1'b1;
                            end
                        end
                    end
                    default: begin
                        if (line) st <= RX_IDLE;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/uxb_filter.sv
// Expansion-bit classifier and station filter: marks address frames,
// keeps the station-match state and raises the receive pulses.
// Assumes fr_valid is a one-cycle pulse per completed frame.
module uxb_filter
    import uxb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  uxb_cfg_t          cfg,
    input  logic [DATA_W-1:0] station_id,
    input  logic              fr_valid,
    input  logic [DATA_W-1:0] fr_data,
    input  logic              fr_xbit,
    input  logic              fr_stop,
    output logic              rx_irq,
    output logic              rx_ferr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_xbit,
    output logic              rx_addr,
    output logic              match_flag
);
    logic det;
    logic filt_on;
    logic id_hit;
    logic take;

    // Classify the frame and decide whether it is delivered
    always_comb begin
        det     = cfg.xen && !cfg.cmp_dis && (fr_xbit == cfg.lvl);
        filt_on = cfg.xen && !cfg.cmp_dis && cfg.filt_en;
        id_hit  = (fr_data == station_id);
        take    = !filt_on || (det ? id_hit : match_flag);
    end

    // Register results, pulses and the station-match state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_irq     <= 1'b0;
            rx_ferr    <= 1'b0;
            rx_data    <= '0;
            rx_xbit    <= 1'b0;
            rx_addr    <= 1'b0;
            match_flag <= 1'b0;
        end else begin
            rx_irq  <= 1'b0;
            rx_ferr <= 1'b0;
            if (!run) begin
                match_flag <= 1'b0;
            end else if (fr_valid) begin
                if (!fr_stop) begin
                    rx_ferr <= 1'b1;
                end else begin
                    if (filt_on && det) match_flag <= id_hit;
                    if (take) begin
                        rx_irq  <= 1'b1;
                        rx_data <= fr_data;
                        rx_xbit <= fr_xbit;
                        rx_addr <= det;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart_xbit_transceiver.sv
// Top level: option register, shared oversampling tick, transmitter,
// receiver framer and station filter.
// Assumes the option register is written only while run is low.
module uart_xbit_transceiver
    import uxb_pkg::*;
#(
    parameter int CLK_DIV = 8,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [DATA_W-1:0] station_id,
    input  logic              tx_start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_xbit,
    output logic              tx_busy,
    output logic              tx_irq,
    output logic              txd,
    input  logic              rxd,
    output logic              rx_irq,
    output logic              rx_ferr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_xbit,
    output logic              rx_addr,
    output logic              match_flag
);
    localparam int CFG_W = $bits(uxb_cfg_t);

    uxb_cfg_t          cfg_q;
    logic              tick;
    logic              fr_valid;
    logic [DATA_W-1:0] fr_data;
    logic              fr_xbit;
    logic              fr_stop;

    // Option register, writable only in idle mode
    always_ff @(posedge clk) begin
        if (!rst_n)               cfg_q <= '0;
        else if (cfg_we && !run)  cfg_q <= uxb_cfg_t'(cfg_wdata[CFG_W-1:0]);
    end

    assign cfg_rdata = {{(8 - CFG_W){1'b0}}, cfg_q};

    uxb_baud #(.CLK_DIV(CLK_DIV)) i_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    uxb_tx #(.DATA_W(DATA_W)) i_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .cfg      (cfg_q),
        .tx_start (tx_start),
        .tx_data  (tx_data),
        .tx_xbit  (tx_xbit),
        .txd      (txd),
        .tx_busy  (tx_busy),
        .tx_irq   (tx_irq)
    );

    uxb_rx #(.DATA_W(DATA_W)) i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .xen      (cfg_q.xen),
        .rxd      (rxd),
        .fr_valid (fr_valid),
        .fr_data  (fr_data),
        .fr_xbit  (fr_xbit),
        .fr_stop  (fr_stop)
    );

    uxb_filter #(.DATA_W(DATA_W)) i_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .cfg        (cfg_q),
        .station_id (station_id),
        .fr_valid   (fr_valid),
        .fr_data    (fr_data),
        .fr_xbit    (fr_xbit),
        .fr_stop    (fr_stop),
        .rx_irq     (rx_irq),
        .rx_ferr    (rx_ferr),
        .rx_data    (rx_data),
        .rx_xbit    (rx_xbit),
        .rx_addr    (rx_addr),
        .match_flag (match_flag)
    );
endmodule

// File: rtl/uxb_checker.sv
// Cycle-level properties of the transceiver, attached by bind.
module uxb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       run,
    input logic [7:0] cfg_rdata,
    input logic       tx_start,
    input logic       tx_busy,
    input logic       tx_irq,
    input logic       txd,
    input logic       rx_irq,
    input logic       rx_ferr,
    input logic       rx_addr,
    input logic       match_flag
);
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7:5] == 3'b000);

    a_r2_locked_when_running: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(cfg_rdata));

    a_r3_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    a_r4_tx_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    a_r5_idle_stops_tx: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tx_busy);

    a_r6_rx_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    a_r7_no_addr_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && (!cfg_rdata[0] || cfg_rdata[4])) |-> !rx_addr);

    a_r8_filtered_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && cfg_rdata[0] && cfg_rdata[2] && !cfg_rdata[4]) |-> match_flag);

    a_r9_ferr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_irq && rx_ferr));

    a_r9_ferr_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ferr |=> !rx_ferr);
endmodule

bind uart_xbit_transceiver uxb_checker i_uxb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .cfg_rdata  (cfg_rdata),
    .tx_start   (tx_start),
    .tx_busy    (tx_busy),
    .tx_irq     (tx_irq),
    .txd        (txd),
    .rx_irq     (rx_irq),
    .rx_ferr    (rx_ferr),
    .rx_addr    (rx_addr),
    .match_flag (match_flag)
);

// File: tb/test_uart_xbit_transceiver.sv
// Scoreboard bench: the driver sends frames through a txd->rxd loopback and
// queues the receive results it expects; a monitor pops and compares them.
module test_uart_xbit_transceiver;
    localparam int CLK_DIV = 8;
    localparam int BIT     = 16 * CLK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [7:0] station_id = 8'h5A;
    logic       tx_start = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_xbit = 1'b0;
    logic       tx_busy, tx_irq, txd;
    logic       rx_irq, rx_ferr, rx_xbit, rx_addr, match_flag;
    logic [7:0] rx_data;
    logic       sel_bfm = 1'b0;
    logic       bfm_line = 1'b1;
    logic       rxd;

    assign rxd = sel_bfm ? bfm_line : txd;

    always #10 clk = ~clk;

    uart_xbit_transceiver #(.CLK_DIV(CLK_DIV), .DATA_W(8)) i_uart_xbit_transceiver (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .station_id(station_id), .tx_start(tx_start),
        .tx_data(tx_data), .tx_xbit(tx_xbit), .tx_busy(tx_busy), .tx_irq(tx_irq),
        .txd(txd), .rxd(rxd), .rx_irq(rx_irq), .rx_ferr(rx_ferr), .rx_data(rx_data),
        .rx_xbit(rx_xbit), .rx_addr(rx_addr), .match_flag(match_flag)
    );

    typedef struct {
        logic [7:0] d;
        logic       xb;
        logic       ad;
        logic       fe;
        string      tag;
    } item_t;

    item_t q[$];
    item_t mit;
    int    nchk  = 0;
    int    nfail = 0;
    int    ntxirq = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Count transmit interrupt pulses
    always @(negedge clk) if (rst_n && tx_irq) ntxirq++;

    // Monitor: pop an expected item for every receive pulse
    always @(negedge clk) begin
        if (rst_n && (rx_irq || rx_ferr)) begin
            if (q.size() == 0) begin
                chk(1'b0, "R8", "unexpected receive pulse", {rx_ferr, rx_data}, 0);
            end else begin
                mit = q.pop_front();
                if (mit.fe) begin
                    chk(rx_ferr && !rx_irq, mit.tag, "framing pulse", {rx_irq, rx_ferr}, 1);
                end else begin
                    chk(rx_irq && !rx_ferr, mit.tag, "rx pulse", {rx_irq, rx_ferr}, 2);
                    chk(rx_data == mit.d, mit.tag, "rx_data", rx_data, mit.d);
                    chk(rx_xbit == mit.xb, mit.tag, "rx_xbit", rx_xbit, mit.xb);
                    chk(rx_addr == mit.ad, mit.tag, "rx_addr", rx_addr, mit.ad);
                end
            end
        end
    end

    task automatic wcfg(input logic [7:0] v);
        @(negedge clk); run = 1'b0; cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0; run = 1'b1;
    endtask

    // Driver: send one frame, queue its expected receive outcome
    task automatic send(input logic [7:0] d, input logic xb, input bit acc,
                        input logic ad, input string tag, input bit poke);
        item_t it;
        int    len;
        int    nb;
        int    irq0;
        bit    endirq;
        endirq = cfg_rdata[3];
        nb     = cfg_rdata[0] ? 11 : 10;
        if (acc) begin
            it.d = d; it.xb = cfg_rdata[0] ? xb : 1'b0; it.ad = ad; it.fe = 1'b0; it.tag = tag;
            q.push_back(it);
        end
        irq0 = ntxirq;
        @(negedge clk); tx_start = 1'b1; tx_data = d; tx_xbit = xb;
        @(negedge clk); tx_start = 1'b0;
        chk(tx_busy, "R3", "busy after start", tx_busy, 1);
        chk(tx_irq == !endirq, "R4", "tx_irq at start", tx_irq, !endirq);
        len = 1;
        while (tx_busy) begin
            @(negedge clk);
            if (tx_busy) len++;
            if (poke && len == 300) begin tx_start = 1'b1; tx_data = ~d; tx_xbit = ~xb; end
            if (poke && len == 301) tx_start = 1'b0;
        end
        chk(tx_irq == endirq, "R4", "tx_irq at end", tx_irq, endirq);
        chk(len > (16 * nb - 1) * CLK_DIV && len <= 16 * nb * CLK_DIV, "R3",
            "frame length", len, 16 * nb * CLK_DIV);
        repeat (BIT) @(negedge clk);
        chk(ntxirq - irq0 == 1, poke ? "R5" : "R4", "tx_irq count", ntxirq - irq0, 1);
        chk(q.size() == 0, tag, "pending items", q.size(), 0);
    endtask

    // Bench-driven frame with a low stop bit
    task automatic bad_frame(input logic [7:0] d, input logic xb);
        item_t it;
        it.d = d; it.xb = xb; it.ad = 1'b0; it.fe = 1'b1; it.tag = "R9";
        q.push_back(it);
        @(negedge clk); sel_bfm = 1'b1; bfm_line = 1'b1;
        @(negedge clk); bfm_line = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin bfm_line = d[i]; repeat (BIT) @(negedge clk); end
        bfm_line = xb; repeat (BIT) @(negedge clk);
        bfm_line = 1'b0; repeat (BIT) @(negedge clk);
        bfm_line = 1'b1; repeat (2 * BIT) @(negedge clk);
        sel_bfm = 1'b0;
        chk(q.size() == 0, "R9", "pending items", q.size(), 0);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R3 watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R10", "txd", txd, 1);
        chk(!tx_busy && !tx_irq && !rx_irq && !rx_ferr, "R10", "outputs",
            {tx_busy, tx_irq, rx_irq, rx_ferr}, 0);
        chk(!match_flag, "R10", "match_flag", match_flag, 0);
        chk(cfg_rdata == 8'h00, "R10", "cfg reset", cfg_rdata, 0);

        // R1: reserved bits read zero
        wcfg(8'hFF);
        chk(cfg_rdata == 8'h1F, "R1", "cfg readback", cfg_rdata, 8'h1F);
        wcfg(8'h00);
        chk(cfg_rdata == 8'h00, "R1", "cfg cleared", cfg_rdata, 0);

        // R2: write while running is ignored
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = 8'h0B;
        @(negedge clk); cfg_we = 1'b0;
        chk(cfg_rdata == 8'h00, "R2", "write while running", cfg_rdata, 0);

        // R6: no expansion bit, interrupt at start
        send(8'hA5, 1'b1, 1, 1'b0, "R6", 0);
        send(8'h00, 1'b0, 1, 1'b0, "R6", 0);

        // R7: expansion on, level 0, interrupt at completion
        wcfg(8'h09);
        send(8'h3C, 1'b1, 1, 1'b0, "R7", 0);
        send(8'h11, 1'b0, 1, 1'b1, "R7", 0);

        // R7: level 1
        wcfg(8'h03);
        send(8'hC3, 1'b1, 1, 1'b1, "R7", 0);
        send(8'h7E, 1'b0, 1, 1'b0, "R7", 0);

        // R7: comparison disabled
        wcfg(8'h13);
        send(8'h81, 1'b1, 1, 1'b0, "R7", 0);

        // R8: filtering with station 5A, level 1
        wcfg(8'h07);
        send(8'h22, 1'b0, 0, 1'b0, "R8", 0);
        chk(!match_flag, "R8", "closed before address", match_flag, 0);
        send(8'h5A, 1'b1, 1, 1'b1, "R8", 0);
        chk(match_flag, "R8", "opened by own id", match_flag, 1);
        send(8'h22, 1'b0, 1, 1'b0, "R8", 0);
        send(8'h33, 1'b1, 0, 1'b0, "R8", 0);
        chk(!match_flag, "R8", "closed by other id", match_flag, 0);
        send(8'h44, 1'b0, 0, 1'b0, "R8", 0);

        // R5: start during a frame is ignored, data latched
        send(8'h5A, 1'b1, 1, 1'b1, "R5", 1);
        chk(match_flag, "R5", "match after latched frame", match_flag, 1);

        // R9: framing error leaves the match state alone
        bad_frame(8'h66, 1'b0);
        chk(match_flag, "R9", "match kept", match_flag, 1);
        send(8'h67, 1'b0, 1, 1'b0, "R9", 0);

        // R5: start ignored while idle
        @(negedge clk); run = 1'b0; tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        chk(!tx_busy && txd, "R5", "start while idle", {tx_busy, txd}, 1);
        chk(!match_flag, "R8", "match cleared when idle", match_flag, 0);
        run = 1'b1;
        repeat (10) @(negedge clk);

        summary();
        $finish;
    end
endmodule